// File: doc/BRIEF.md
# Soft Mute Ramp Sequencer

The sequencer produces a per-sample gain coefficient that glides between silence and unity gain. A downstream multiplier, outside this block, applies the coefficient to the audio. An active-low mute request picks the direction of the glide. The glide moves one step on each sample strobe and can turn around part-way, continuing from wherever it stands.

The block also guards changes to the processing configuration: a multi-bit mode select and a one-bit attack select. Each raw pin passes through a glitch filter, which accepts a new level only after it has been seen on two consecutive sample strobes. When an accepted setting differs from the one in use, the sequencer takes these steps:

- It forces the gain down to silence.
- It raises a one-cycle apply pulse and latches the new setting.
- It glides back up.

If the gain is already at silence, the apply step follows at once. After reset, an initialization phase of four sample strobes holds the output silent and latches the first setting.

The controller has five states: `ST_INIT`, `ST_RUN`, `ST_FADE`, `ST_APPLY` and `ST_RECOVER`. Its transitions are:

- `ST_INIT -> ST_APPLY` once four strobes have passed and the filtered pins are settled.
- `ST_RUN -> ST_FADE` when the filtered setting differs from the latched one.
- `ST_FADE -> ST_APPLY` when the gain is at silence and the filtered pins are settled.
- `ST_APPLY -> ST_RECOVER` unconditionally, after one cycle.
- `ST_RECOVER -> ST_FADE` on another setting change.
- `ST_RECOVER -> ST_RUN` when unity is reached or the mute request is active.

Top module: `mute_ramp_seq`

## Requirements
- R1: After reset is released, the coefficient is 0 and force_mute_o is high for the first four sample strobes. No apply pulse occurs before the fourth strobe.
- R2: The internal level runs from 0 to 1024. The coefficient is level*64 for levels below 1024 and 65535 at level 1024, so 0 is silence and 65535 is unity.
- R3: The level changes by at most one step per sample strobe and never moves without a strobe. A full sweep between silence and unity takes 1024 strobes, and the level saturates at either end.
- R4: With mute_n_i low the level steps toward 0; with mute_n_i high it steps toward 1024. A change of mute_n_i during a glide reverses it from the current level.
- R5: A configuration pin level is accepted only after it has been sampled on two consecutive strobes. A level present on a single strobe changes nothing and starts no sequence.
- R6: When an accepted setting differs from the latched one while the gain is above silence, force_mute_o rises and the level steps down to 0. Then apply_o pulses, the new setting is latched, and the level steps back up to unity.
- R7: When the gain is already at silence, an accepted change is applied within three clock cycles, with no further strobe needed.
- R8: A setting change accepted while the gain is recovering after an apply restarts the fade from the current level. A new apply follows when the level reaches 0.
- R9: An active mute request overrides the recovery phase: force_mute_o drops and the level steps toward 0.
- R10: apply_o lasts exactly one clock cycle. mode_o and attack_o change only in the cycle after apply_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs_strobe_i | input | 1 | One-cycle pulse per audio sample period |
| mute_n_i | input | 1 | Mute request, active low |
| mode_pins_i | input | MODE_W | Raw mode-select pins |
| attack_pin_i | input | 1 | Raw attack-select pin |
| gain_coef_o | output | COEF_W | Unsigned gain coefficient, 0 = silence, all ones = unity |
| apply_o | output | 1 | One-cycle pulse when a new setting takes effect |
| force_mute_o | output | 1 | High while the sequencer forces silence (initialization, fade, apply) |
| mode_o | output | MODE_W | Latched mode setting |
| attack_o | output | 1 | Latched attack setting |

## Verification
Assertions check on every cycle that the level moves only on strobes and by one step at most, and that it never rises while muting is forced or requested. They also check that apply happens only at silence and lasts one cycle, that the latched settings move only after apply, and that the filtered pins change only on strobes. Only the directed scenarios can show the exact coefficient after a given number of strobes. The same holds for the four-strobe initialization, the two-strobe acceptance and rejection of single-strobe glitches, reversal from mid-glide, the immediate apply at silence, and the restarted fade during recovery.

// File: rtl/mute_ramp_pkg.sv
package mute_ramp_pkg;
    typedef enum logic [2:0] {
        ST_INIT,
        ST_RUN,
        ST_FADE,
        ST_APPLY,
        ST_RECOVER
    } seq_state_t;
endpackage

// File: rtl/mrs_pin_filter.sv
module mrs_pin_filter #(
    parameter int HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic raw_i,
    output logic filt_o,
    output logic settled_o
);
    localparam int CW = $clog2(HOLD + 1);

    logic          cand_q;
    logic [CW-1:0] run_q;
    logic          filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= 1'b0;
            run_q  <= CW'(HOLD);
            filt_q <= 1'b0;
        end else if (strobe_i) begin
            if (raw_i != cand_q) begin
                cand_q <= raw_i;
                run_q  <= CW'(1);
            end else if (run_q != CW'(HOLD)) begin
                run_q <= run_q + 1'b1;
                if (run_q == CW'(HOLD - 1)) begin
                    filt_q <= cand_q;
                end
            end
        end
    end

    assign filt_o    = filt_q;
    assign settled_o = (cand_q == filt_q);

    AST_FILT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> $stable(filt_q)); // R5
    AST_FILT_NEEDS_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && (raw_i != cand_q)) |=> $stable(filt_q)); // R5
endmodule

// File: rtl/mrs_ramp_core.sv
module mrs_ramp_core #(
    parameter int RAMP_BITS = 10,
    parameter int COEF_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic              clear_i,
    input  logic              up_i,
    output logic [COEF_W-1:0] coef_o,
    output logic              at_floor_o,
    output logic              at_ceil_o
);
    localparam int LW  = RAMP_BITS + 1;
    localparam int PAD = COEF_W - RAMP_BITS;
    localparam logic [LW-1:0] CEIL = {1'b1, {RAMP_BITS{1'b0}}};

    logic [LW-1:0] level_q;

    assign at_floor_o = (level_q == '0);
    assign at_ceil_o  = (level_q == CEIL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (clear_i) begin
            level_q <= '0;
        end else if (strobe_i) begin
            if (up_i && !at_ceil_o) begin
                level_q <= level_q + 1'b1;
            end else if (!up_i && !at_floor_o) begin
                level_q <= level_q - 1'b1;
            end
        end
    end

    generate
        if (PAD > 0) begin : g_widen
            assign coef_o = at_ceil_o ? {COEF_W{1'b1}}
                                      : {level_q[RAMP_BITS-1:0], {PAD{1'b0}}};
        end else begin : g_narrow
            assign coef_o = at_ceil_o ? {COEF_W{1'b1}}
                                      : level_q[RAMP_BITS-1 -: COEF_W];
        end
    endgenerate

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= CEIL); // R2
    AST_HOLD_BETWEEN_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_i && !clear_i) |=> $stable(level_q)); // R3
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && !clear_i) |=> ((level_q == $past(level_q)) ||
                                    (level_q == $past(level_q) + 1'b1) ||
                                    (level_q + 1'b1 == $past(level_q)))); // R3
endmodule

// File: rtl/mrs_seq_fsm.sv
module mrs_seq_fsm
    import mute_ramp_pkg::*;
#(
    parameter int INIT_SAMPLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic mute_req_i,
    input  logic cfg_diff_i,
    input  logic cfg_settled_i,
    input  logic at_floor_i,
    input  logic at_ceil_i,
    output logic clear_o,
    output logic up_o,
    output logic apply_o,
    output logic force_mute_o
);
    localparam int IW = $clog2(INIT_SAMPLES + 1);

    seq_state_t    state_q;
    seq_state_t    state_d;
    logic [IW-1:0] init_cnt_q;
    logic          init_done;

    assign init_done = (init_cnt_q == IW'(INIT_SAMPLES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_cnt_q <= '0;
        end else if ((state_q == ST_INIT) && strobe_i && !init_done) begin
            init_cnt_q <= init_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: begin
                if (init_done && cfg_settled_i) state_d = ST_APPLY;
            end
            ST_RUN: begin
                if (cfg_diff_i) state_d = ST_FADE;
            end
            ST_FADE: begin
                if (at_floor_i && cfg_settled_i) state_d = ST_APPLY;
            end
            ST_APPLY: begin
                state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (cfg_diff_i)                    state_d = ST_FADE;
                else if (mute_req_i || at_ceil_i)  state_d = ST_RUN;
            end
            default: state_d = ST_INIT;
        endcase
    end

    always_comb begin
        clear_o      = 1'b0;
        up_o         = 1'b0;
        apply_o      = 1'b0;
        force_mute_o = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                clear_o      = 1'b1;
                force_mute_o = 1'b1;
            end
            ST_RUN, ST_RECOVER: begin
                up_o = !mute_req_i;
            end
            ST_FADE: begin
                force_mute_o = 1'b1;
            end
            ST_APPLY: begin
                apply_o      = 1'b1;
                force_mute_o = 1'b1;
            end
            default: begin
                clear_o      = 1'b1;
                force_mute_o = 1'b1;
            end
        endcase
    end

    AST_INIT_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT) |-> at_floor_i); // R1
    AST_APPLY_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |-> at_floor_i); // R6
    AST_APPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        apply_o |=> !apply_o); // R10
endmodule

// File: rtl/mute_ramp_seq.sv
module mute_ramp_seq #(
    parameter int RAMP_BITS    = 10,
    parameter int COEF_W       = 16,
    parameter int MODE_W       = 3,
    parameter int INIT_SAMPLES = 4,
    parameter int HOLD_SAMPLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_strobe_i,
    input  logic              mute_n_i,
    input  logic [MODE_W-1:0] mode_pins_i,
    input  logic              attack_pin_i,
    output logic [COEF_W-1:0] gain_coef_o,
    output logic              apply_o,
    output logic              force_mute_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              attack_o
);
    localparam int CFG_W = MODE_W + 1;

    logic [CFG_W-1:0] raw_cfg;
    logic [CFG_W-1:0] filt_cfg;
    logic [CFG_W-1:0] settled_bits;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_settled;
    logic             cfg_diff;
    logic             ramp_clear;
    logic             ramp_up;
    logic             at_floor;
    logic             at_ceil;

    assign raw_cfg     = {mode_pins_i, attack_pin_i};
    assign cfg_settled = &settled_bits;
    assign cfg_diff    = (filt_cfg != cfg_q);

    generate
        for (genvar g = 0; g < CFG_W; g++) begin : g_pin
            mrs_pin_filter #(
                .HOLD(HOLD_SAMPLES)
            ) u_filter (
                .clk      (clk),
                .rst_n    (rst_n),
                .strobe_i (fs_strobe_i),
                .raw_i    (raw_cfg[g]),
                .filt_o   (filt_cfg[g]),
                .settled_o(settled_bits[g])
            );
        end
    endgenerate

    mrs_seq_fsm #(
        .INIT_SAMPLES(INIT_SAMPLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_i     (fs_strobe_i),
        .mute_req_i   (!mute_n_i),
        .cfg_diff_i   (cfg_diff),
        .cfg_settled_i(cfg_settled),
        .at_floor_i   (at_floor),
        .at_ceil_i    (at_ceil),
        .clear_o      (ramp_clear),
        .up_o         (ramp_up),
        .apply_o      (apply_o),
        .force_mute_o (force_mute_o)
    );

    mrs_ramp_core #(
        .RAMP_BITS(RAMP_BITS),
        .COEF_W   (COEF_W)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (fs_strobe_i),
        .clear_i   (ramp_clear),
        .up_i      (ramp_up),
        .coef_o    (gain_coef_o),
        .at_floor_o(at_floor),
        .at_ceil_o (at_ceil)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (apply_o) begin
            cfg_q <= filt_cfg;
        end
    end

    assign mode_o   = cfg_q[CFG_W-1:1];
    assign attack_o = cfg_q[0];

    AST_FORCE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (force_mute_o && fs_strobe_i) |=> (gain_coef_o <= $past(gain_coef_o))); // R6
    AST_MUTE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_n_i && fs_strobe_i) |=> (gain_coef_o <= $past(gain_coef_o))); // R9
    AST_SETTINGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_o |=> $stable({mode_o, attack_o})); // R10
endmodule

// File: tb/mute_ramp_seq_test.sv
module mute_ramp_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fs_strobe_i;
    logic        mute_n_i;
    logic [2:0]  mode_pins_i;
    logic        attack_pin_i;
    logic [15:0] gain_coef_o;
    logic        apply_o;
    logic        force_mute_o;
    logic [2:0]  mode_o;
    logic        attack_o;

    int total = 0;
    int bad = 0;
    int apply_cnt = 0;
    bit done = 0;

    mute_ramp_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_strobe_i (fs_strobe_i),
        .mute_n_i    (mute_n_i),
        .mode_pins_i (mode_pins_i),
        .attack_pin_i(attack_pin_i),
        .gain_coef_o (gain_coef_o),
        .apply_o     (apply_o),
        .force_mute_o(force_mute_o),
        .mode_o      (mode_o),
        .attack_o    (attack_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) if (apply_o) apply_cnt++;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic strobes(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) fs_strobe_i = 1'b1;
            @(negedge clk) fs_strobe_i = 1'b0;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_init();
        chk("R1 coef in reset", gain_coef_o, 0);
        chk("R1 force in reset", force_mute_o, 1);
        @(negedge clk) rst_n = 1'b1;
        strobes(3);
        idle(3);
        chk("R1 no apply before 4 strobes", apply_cnt, 0);
        chk("R1 force during init", force_mute_o, 1);
        chk("R1 coef during init", gain_coef_o, 0);
        strobes(1);
        idle(3);
        chk("R1 apply after init", apply_cnt, 1);
        chk("R10 mode latched", mode_o, 5);
        chk("R10 attack latched", attack_o, 1);
        chk("R1 force released", force_mute_o, 0);
    endtask

    task automatic t_ramp();
        strobes(512);
        chk("R2 half level", gain_coef_o, 32768);
        strobes(511);
        chk("R3 one short of full", gain_coef_o, 65472);
        strobes(1);
        chk("R2 unity after 1024", gain_coef_o, 65535);
        strobes(2);
        chk("R3 saturate at unity", gain_coef_o, 65535);
    endtask

    task automatic t_reverse();
        mute_n_i = 1'b0;
        strobes(300);
        chk("R4 mute glide", gain_coef_o, 724 * 64);
        mute_n_i = 1'b1;
        strobes(100);
        chk("R4 reversal from current", gain_coef_o, 824 * 64);
        mute_n_i = 1'b0;
        strobes(900);
        chk("R3 saturate at silence", gain_coef_o, 0);
        chk("R4 no forced mute", force_mute_o, 0);
    endtask

    task automatic t_muted_apply();
        int base = apply_cnt;
        mode_pins_i = 3'b011;
        strobes(1);
        idle(4);
        chk("R5 one strobe not accepted", apply_cnt, base);
        chk("R5 mode unchanged", mode_o, 5);
        strobes(1);
        idle(4);
        chk("R7 immediate apply", apply_cnt, base + 1);
        chk("R7 mode latched", mode_o, 3);
        chk("R7 coef stays silent", gain_coef_o, 0);
    endtask

    task automatic t_glitch();
        int base;
        mute_n_i = 1'b1;
        strobes(1024);
        chk("R4 back to unity", gain_coef_o, 65535);
        base = apply_cnt;
        attack_pin_i = 1'b0;
        strobes(1);
        attack_pin_i = 1'b1;
        strobes(3);
        idle(4);
        chk("R5 glitch no apply", apply_cnt, base);
        chk("R5 glitch no fade", gain_coef_o, 65535);
        chk("R5 glitch no force", force_mute_o, 0);
        chk("R5 attack kept", attack_o, 1);
    endtask

    task automatic t_change_live();
        int base = apply_cnt;
        attack_pin_i = 1'b0;
        strobes(2);
        idle(1);
        chk("R6 force raised", force_mute_o, 1);
        chk("R6 coef before fade", gain_coef_o, 65535);
        strobes(1);
        chk("R6 first fade step", gain_coef_o, 65472);
        strobes(1022);
        chk("R6 near silence", gain_coef_o, 64);
        chk("R10 attack not yet changed", attack_o, 1);
        strobes(1);
        idle(3);
        chk("R6 apply at silence", apply_cnt, base + 1);
        chk("R6 attack latched", attack_o, 0);
        chk("R6 force dropped", force_mute_o, 0);
        strobes(1024);
        chk("R6 recovered to unity", gain_coef_o, 65535);
    endtask

    task automatic t_restart();
        int base = apply_cnt;
        mode_pins_i = 3'b110;
        strobes(2);
        idle(1);
        strobes(1024);
        idle(3);
        chk("R6 second apply", apply_cnt, base + 1);
        strobes(200);
        chk("R8 recovering", gain_coef_o, 200 * 64);
        mode_pins_i = 3'b001;
        strobes(2);
        idle(1);
        chk("R8 fade restarted", force_mute_o, 1);
        chk("R8 level kept", gain_coef_o, 202 * 64);
        chk("R10 mode held", mode_o, 6);
        strobes(202);
        idle(3);
        chk("R8 apply after restart", apply_cnt, base + 2);
        chk("R8 new mode", mode_o, 1);
    endtask

    task automatic t_override();
        strobes(100);
        chk("R9 recovery rising", gain_coef_o, 6400);
        mute_n_i = 1'b0;
        idle(1);
        chk("R9 force low under mute", force_mute_o, 0);
        strobes(50);
        chk("R9 falling", gain_coef_o, 3200);
        strobes(50);
        chk("R9 silent", gain_coef_o, 0);
    endtask

    initial begin
        rst_n        = 1'b0;
        fs_strobe_i  = 1'b0;
        mute_n_i     = 1'b1;
        mode_pins_i  = 3'b101;
        attack_pin_i = 1'b1;
        idle(3);
        t_init();
        t_ramp();
        t_reverse();
        t_muted_apply();
        t_glitch();
        t_change_live();
        t_restart();
        t_override();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule